// File: doc/BRIEF.md
# Fault-Driven Output High-Impedance Controller

This block decides when the output pins of a PWM timer must be released to high impedance. There are three pin groups. Group 0 is a single-channel group. Groups 1 and 2 are complementary-PWM channel pairs. Several fault sources can force a group off:

- a software request bit for each group;
- an oscillator-stop indication;
- three comparator detection inputs;
- three active-low external fault pins;
- a detector that flags a complementary pair whose high-side and low-side drives are both active at once.

Every fault source latches a sticky flag. A group goes to high impedance while any condition that is enabled for it is latched, or while its software bit is set. Only the pins picked in that group's pin-select register are affected.

Recovery is deliberately guarded. A fault pin sampled in one of the level modes can be cleared only after the pin has been seen high again. A pair-conflict flag can be cleared only while the timer reports that its count is stopped, which means the outputs sit at their inactive level. Software reaches the block through a simple write port and a registered read port with 3-bit addresses and 16-bit data.

Top module: `hiz_guard`

## Requirements
- R1: After reset, every register reads 0, all flags are 0 and every `hiz_o` bit is 0.
- R2: The register map is as follows.
  - Address 0 holds the software request bits, bit g for group g.
  - Address 1 holds the fault-pin enables, bit 3g+k letting pin k act on group g.
  - Address 2 holds the comparator enables in bits 2:0 (one per group), the oscillator-stop enable in bit 3, and the pair-conflict enables in bits 5:4 (bit 4 for group 1, bit 5 for group 2).
  - Address 3 holds the sampling modes, bits 2k+1:2k for pin k.
  - Addresses 4, 5 and 6 hold the pin selects of groups 0, 1 and 2.
  - Address 7 holds the flags: bits 2:0 are the fault pins, bits 5:3 the comparators, bit 6 oscillator stop, and bits 8:7 the pair conflicts of groups 1 and 2.
  - `rd_data` shows the register at `rd_addr` one cycle later.
- R3: A set software request bit g drives the selected pins of group g high impedance from the cycle after the write. Clearing the bit releases them.
- R4: A `hiz_o` bit is never high unless its pin-select bit was set in the previous cycle. Group g occupies `hiz_o` bits g*GRP_PINS and up.
- R5: `osc_stop` sets the oscillator-stop flag whatever its enable. The flag forces all three groups only while enable bit 3 is set.
- R6: `cmp_det[i]` sets comparator flag i. Any latched comparator flag forces group g only when comparator enable bit g is set.
- R7: Fault-pin modes are 0 (falling edge), 1 (low for 8 consecutive samples), 2 (low for 16) and 3 (low for 128). A pin is synchronised through two flops.
- R8: In a level mode, writing 0 to a fault-pin flag is ignored until the pin has been sampled high after the flag was set. In edge mode the write clears the flag at once.
- R9: A conflict in pair j (both `pwm_hi` and `pwm_lo` high on any phase of that pair) sets its flag. Writing 0 clears that flag only while `timer_stop` is 1.
- R10: Flags ignore writes of 1. A flag is cleared only by a write of 0 to its bit. A flag whose source is still active stays set.
- R11: A group whose fault-pin condition comes from several pins stays high impedance until every enabled latched pin flag is cleared. Flags of pins that are not enabled for a group do not affect that group.
- R12: `flags_o` always mirrors the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| osc_stop | input | 1 | Oscillator-stop indication |
| cmp_det | input | 3 | Comparator detection inputs |
| flt_n | input | 3 | Active-low external fault pins |
| pwm_hi | input | 2*PHASES | High-side drives, pair j at bits j*PHASES and up |
| pwm_lo | input | 2*PHASES | Low-side drives, same layout as `pwm_hi` |
| timer_stop | input | 1 | Timer count stopped (outputs at inactive level) |
| hiz_o | output | 3*GRP_PINS | Per-pin high-impedance requests |
| flags_o | output | 9 | Current fault flags |

## Verification
The bench samples at falling edges and plans each check from these latencies:

| Stimulus | Result | Due |
|---|---|---|
| Register write | `hiz_o` | next cycle |
| Comparator, oscillator-stop or conflict input | flag | 1 cycle later |
| Comparator, oscillator-stop or conflict input | `hiz_o` | 2 cycles later |
| Fault pin in edge mode (N = 1) | flag | 2+N cycles after the pin changes |
| Fault pin, level mode of N samples | flag | 2+N cycles after the pin changes |
| Fault pin (any mode) | `hiz_o` | 3+N cycles after the pin changes |
| Read address | `rd_data` | 1 cycle later |

For each mode of each fault pin, `hiz_o` is checked to be still low at cycle 2+N and high at cycle 3+N. This pins the sampling window exactly. The bench's expected outputs come from its own model of the enables and latched flags.

// File: rtl/hiz_guard_pkg.sv
package hiz_guard_pkg;
  localparam int NGRP  = 3;
  localparam int NFLT  = 3;
  localparam int NCMP  = 3;
  localparam int NPAIR = NGRP - 1;
  localparam int DW    = 16;
  localparam int AW    = 3;
  localparam int NFLAG = NFLT + NCMP + 1 + NPAIR;
  localparam int CNTW  = 8;

  localparam logic [AW-1:0] A_SWREQ  = 3'd0;
  localparam logic [AW-1:0] A_INMASK = 3'd1;
  localparam logic [AW-1:0] A_MISC   = 3'd2;
  localparam logic [AW-1:0] A_MODE   = 3'd3;
  localparam logic [AW-1:0] A_PSEL0  = 3'd4;
  localparam logic [AW-1:0] A_FLAGS  = 3'd7;

  typedef enum logic [1:0] {
    MD_EDGE = 2'd0,
    MD_L8   = 2'd1,
    MD_L16  = 2'd2,
    MD_L128 = 2'd3
  } smode_t;

  function automatic logic [CNTW-1:0] run_len(smode_t m);
    case (m)
      MD_L8:   return CNTW'(8);
      MD_L16:  return CNTW'(16);
      MD_L128: return CNTW'(128);
      default: return CNTW'(1);
    endcase
  endfunction
endpackage

// File: rtl/hiz_tick.sv
module hiz_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'((DIV > 1) ? DIV - 1 : 0);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/hiz_pin_det.sv
module hiz_pin_det
  import hiz_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   pin_n,
  input  smode_t mode,
  input  logic   clr_req,
  output logic   flag
);
  logic [2:0]      sh;      // sh[1] synchronised level, sh[2] previous
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] lim;
  logic            seen_hi;
  logic            fall, at_lim, hit, set, may_clr;

  always_comb begin
    lim     = run_len(mode) - 1'b1;
    fall    = sh[2] & ~sh[1];
    at_lim  = (cnt >= lim);
    hit     = tick & ~sh[1] & at_lim;
    set     = (mode == MD_EDGE) ? fall : hit;
    may_clr = (mode == MD_EDGE) | seen_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= 3'b111;
      cnt     <= '0;
      seen_hi <= 1'b0;
      flag    <= 1'b0;
    end else begin
      sh <= {sh[1:0], pin_n};
      if (tick) begin
        if (sh[1]) cnt <= '0;
        else if (!at_lim) cnt <= cnt + 1'b1;
      end
      if (set) seen_hi <= 1'b0;
      else if (tick && sh[1]) seen_hi <= 1'b1;
      if (set) flag <= 1'b1;
      else if (clr_req && may_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hiz_grp_out.sv
module hiz_grp_out
  import hiz_guard_pkg::*;
#(
  parameter int GP = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw,
  input  logic            ost_act,
  input  logic            cmp_en,
  input  logic            cmp_any,
  input  logic [NFLT-1:0] in_mask,
  input  logic [NFLT-1:0] in_flag,
  input  logic            ocd_term,
  input  logic [GP-1:0]   pinsel,
  output logic [GP-1:0]   hiz
);
  logic cond;

  assign cond = sw | ost_act | (cmp_en & cmp_any) | (|(in_mask & in_flag)) | ocd_term;

  always_ff @(posedge clk) begin
    if (rst) hiz <= '0;
    else hiz <= cond ? pinsel : '0;
  end
endmodule

// File: rtl/hiz_guard.sv
module hiz_guard
  import hiz_guard_pkg::*;
#(
  parameter int GRP_PINS   = 6,
  parameter int PHASES     = 3,
  parameter int SAMPLE_DIV = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data,
  input  logic                      osc_stop,
  input  logic [NCMP-1:0]           cmp_det,
  input  logic [NFLT-1:0]           flt_n,
  input  logic [NPAIR*PHASES-1:0]   pwm_hi,
  input  logic [NPAIR*PHASES-1:0]   pwm_lo,
  input  logic                      timer_stop,
  output logic [NGRP*GRP_PINS-1:0]  hiz_o,
  output logic [NFLAG-1:0]          flags_o
);
  localparam int MASKW = NGRP * NFLT;
  localparam int F_IN  = 0;
  localparam int F_CMP = NFLT;
  localparam int F_OST = NFLT + NCMP;
  localparam int F_OCD = F_OST + 1;
  localparam int M_OST = NGRP;
  localparam int M_OCD = NGRP + 1;
  localparam int GW    = $clog2(NGRP);

  // configuration
  logic [NGRP-1:0]                sw_q;
  logic [MASKW-1:0]               mask_q;
  logic [NGRP-1:0]                cmp_en_q;
  logic                           ost_en_q;
  logic [NPAIR-1:0]               ocd_en_q;
  logic [2*NFLT-1:0]              mode_q;
  logic [NGRP-1:0][GRP_PINS-1:0]  pinsel_q;

  // flags
  logic [NFLT-1:0]  in_f;
  logic [NCMP-1:0]  cmp_f;
  logic             ost_f;
  logic [NPAIR-1:0] ocd_f;
  logic [NPAIR-1:0] conflict;

  logic             tick;
  logic [NFLAG-1:0] clr;
  logic [GW-1:0]    widx, ridx;
  logic [DW-1:0]    rd_mux;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DW-1:MASKW];
  assign widx = GW'(wr_addr - A_PSEL0);
  assign ridx = GW'(rd_addr - A_PSEL0);
  assign clr  = {NFLAG{wr_en && (wr_addr == A_FLAGS)}} & ~wr_data[NFLAG-1:0];

  hiz_tick #(.DIV(SAMPLE_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q     <= '0;
      mask_q   <= '0;
      cmp_en_q <= '0;
      ost_en_q <= 1'b0;
      ocd_en_q <= '0;
      mode_q   <= '0;
      pinsel_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_SWREQ:  sw_q   <= wr_data[NGRP-1:0];
        A_INMASK: mask_q <= wr_data[MASKW-1:0];
        A_MISC: begin
          cmp_en_q <= wr_data[NGRP-1:0];
          ost_en_q <= wr_data[M_OST];
          ocd_en_q <= wr_data[M_OCD +: NPAIR];
        end
        A_MODE:   mode_q <= wr_data[2*NFLT-1:0];
        A_FLAGS:  ;
        default: begin
          if (wr_addr >= A_PSEL0 && wr_addr < A_FLAGS)
            pinsel_q[widx] <= wr_data[GRP_PINS-1:0];
        end
      endcase
    end
  end

  // pair conflict detection
  always_comb begin
    for (int j = 0; j < NPAIR; j++)
      conflict[j] = |(pwm_hi[j*PHASES +: PHASES] & pwm_lo[j*PHASES +: PHASES]);
  end

  // single-cycle fault sources
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_f <= '0;
      ost_f <= 1'b0;
      ocd_f <= '0;
    end else begin
      for (int i = 0; i < NCMP; i++) begin
        if (cmp_det[i]) cmp_f[i] <= 1'b1;
        else if (clr[F_CMP+i]) cmp_f[i] <= 1'b0;
      end
      if (osc_stop) ost_f <= 1'b1;
      else if (clr[F_OST]) ost_f <= 1'b0;
      for (int j = 0; j < NPAIR; j++) begin
        if (conflict[j]) ocd_f[j] <= 1'b1;
        else if (clr[F_OCD+j] && timer_stop) ocd_f[j] <= 1'b0;
      end
    end
  end

  // external fault pins
  for (genvar k = 0; k < NFLT; k++) begin : g_pin
    hiz_pin_det u_det (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .pin_n  (flt_n[k]),
      .mode   (smode_t'(mode_q[2*k +: 2])),
      .clr_req(clr[F_IN+k]),
      .flag   (in_f[k])
    );
  end

  // per-group output stage
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic ocd_t;
    if (g == 0) begin : g_single
      assign ocd_t = 1'b0;
    end else begin : g_pair
      assign ocd_t = ocd_en_q[g-1] & ocd_f[g-1];
    end
    hiz_grp_out #(.GP(GRP_PINS)) u_out (
      .clk     (clk),
      .rst     (rst),
      .sw      (sw_q[g]),
      .ost_act (ost_en_q & ost_f),
      .cmp_en  (cmp_en_q[g]),
      .cmp_any (|cmp_f),
      .in_mask (mask_q[g*NFLT +: NFLT]),
      .in_flag (in_f),
      .ocd_term(ocd_t),
      .pinsel  (pinsel_q[g]),
      .hiz     (hiz_o[g*GRP_PINS +: GRP_PINS])
    );
  end

  assign flags_o = {ocd_f, ost_f, cmp_f, in_f};

  // read port
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_SWREQ:  rd_mux[NGRP-1:0]  = sw_q;
      A_INMASK: rd_mux[MASKW-1:0] = mask_q;
      A_MISC: begin
        rd_mux[NGRP-1:0]       = cmp_en_q;
        rd_mux[M_OST]          = ost_en_q;
        rd_mux[M_OCD +: NPAIR] = ocd_en_q;
      end
      A_MODE:   rd_mux[2*NFLT-1:0] = mode_q;
      A_FLAGS:  rd_mux[NFLAG-1:0]  = flags_o;
      default: begin
        if (rd_addr >= A_PSEL0 && rd_addr < A_FLAGS)
          rd_mux[GRP_PINS-1:0] = pinsel_q[ridx];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else rd_data <= rd_mux;
  end
endmodule

// File: rtl/hiz_guard_chk.sv
module hiz_guard_chk #(
  parameter int GP = 6,
  parameter int NG = 3,
  parameter int NF = 9
) (
  input logic            clk,
  input logic            rst,
  input logic [NG*GP-1:0] hiz_o,
  input logic [NG*GP-1:0] pinsel_all,
  input logic [NF-1:0]   flags_o,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic [15:0]     wr_data,
  input logic            timer_stop,
  input logic            ost_act
);
  // R1: leaving reset, outputs and flags are clear
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (hiz_o == '0 && flags_o == '0));

  // R4: only selected pins ever go high impedance
  a_r4_only_selected: assert property (@(posedge clk) disable iff (rst)
    (hiz_o & ~$past(pinsel_all)) == '0);

  // R5: enabled oscillator stop forces every selected pin
  a_r5_osc_all: assert property (@(posedge clk) disable iff (rst)
    $past(ost_act) |-> (hiz_o == $past(pinsel_all)));

  for (genvar i = 0; i < NF; i++) begin : g_flag
    // R10: a flag falls only after a write of 0 to its bit
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      $fell(flags_o[i]) |-> $past(wr_en && wr_addr == 3'd7 && !wr_data[i]));
  end

  for (genvar j = NF - 2; j < NF; j++) begin : g_ocd
    // R9: conflict flag clears only while the timer is stopped
    a_r9_clear_stopped: assert property (@(posedge clk) disable iff (rst)
      $fell(flags_o[j]) |-> $past(timer_stop));
  end
endmodule

bind hiz_guard hiz_guard_chk #(.GP(GRP_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hiz_o     (hiz_o),
  .pinsel_all(pinsel_q),
  .flags_o   (flags_o),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .timer_stop(timer_stop),
  .ost_act   (ost_en_q & ost_f)
);

// File: tb/sim_hiz_guard.sv
module sim_hiz_guard;
  localparam int GP = 6;
  localparam int PH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        osc_stop = 1'b0;
  logic [2:0]  cmp_det = '0;
  logic [2:0]  flt_n = 3'b111;
  logic [2*PH-1:0] pwm_hi = '0;
  logic [2*PH-1:0] pwm_lo = '0;
  logic        timer_stop = 1'b0;
  logic [3*GP-1:0] hiz_o;
  logic [8:0]  flags_o;

  always #10 clk = ~clk;

  hiz_guard #(.GRP_PINS(GP), .PHASES(PH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .osc_stop(osc_stop), .cmp_det(cmp_det),
    .flt_n(flt_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .timer_stop(timer_stop),
    .hiz_o(hiz_o), .flags_o(flags_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [2:0] m_sw = '0, m_cmpen = '0, m_inf = '0, m_cmpf = '0;
  logic [8:0] m_mask = '0;
  logic       m_osten = 1'b0, m_ostf = 1'b0;
  logic [1:0] m_ocden = '0, m_ocdf = '0;
  logic [GP-1:0] m_psel [3];

  function automatic logic [3*GP-1:0] exp_hiz();
    logic [3*GP-1:0] r = '0;
    for (int g = 0; g < 3; g++) begin
      logic c;
      c = m_sw[g] | (m_osten & m_ostf) | (m_cmpen[g] & (|m_cmpf)) |
          (|(m_mask[g*3 +: 3] & m_inf));
      if (g > 0) c = c | (m_ocden[g-1] & m_ocdf[g-1]);
      if (c) r[g*GP +: GP] = m_psel[g];
    end
    return r;
  endfunction

  function automatic logic [8:0] exp_flags();
    return {m_ocdf, m_ostf, m_cmpf, m_inf};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    chk({tag, " hiz"}, 32'(hiz_o), 32'(exp_hiz()));
    chk({tag, " flags"}, 32'(flags_o), 32'(exp_flags()));
  endtask

  task automatic set_psel(input logic [GP-1:0] p0, p1, p2);
    m_psel[0] = p0; m_psel[1] = p1; m_psel[2] = p2;
    wr(3'd4, 16'(p0)); wr(3'd5, 16'(p1)); wr(3'd6, 16'(p2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    for (int g = 0; g < 3; g++) m_psel[g] = '0;
    cyc(4);
    rst = 1'b0;
    cyc(1);

    // R1: reset state
    chk_out("R1");
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reg", 32'(d), 32'd0);
    end

    // R3 / R4: software requests over all patterns with varying selects
    for (int s = 0; s < 8; s++) begin
      set_psel(GP'(s * 7 + 5), GP'(s * 11 + 3), GP'(63 - s * 5));
      m_sw = 3'(s);
      wr(3'd0, 16'(s));
      cyc(1);
      chk_out("R3 R4 swreq");
    end
    m_sw = '0; wr(3'd0, 16'd0); cyc(1);
    chk_out("R3 release");

    // R2: readback of configuration registers
    rd(3'd5, d); chk("R2 psel1", 32'(d), 32'(m_psel[1]));
    rd(3'd0, d); chk("R2 swreq", 32'(d), 32'd0);

    // R6: comparator flags against every enable pattern
    set_psel(6'h3F, 6'h15, 6'h2A);
    for (int e = 0; e < 8; e++) begin
      m_cmpen = 3'(e);
      wr(3'd2, 16'(e));
      for (int i = 0; i < 3; i++) begin
        cmp_det[i] = 1'b1;
        @(negedge clk);
        cmp_det[i] = 1'b0;
        m_cmpf[i] = 1'b1;
        @(negedge clk);
        chk_out("R6 cmp");
        m_cmpf = '0;
        wr(3'd7, 16'd0);
        cyc(1);
        chk_out("R6 clear");
      end
    end
    rd(3'd2, d); chk("R2 misc", 32'(d), 32'd7);

    // R10: held source keeps its flag; writes of 1 do nothing
    cmp_det[1] = 1'b1;
    cyc(1); m_cmpf[1] = 1'b1;
    wr(3'd7, 16'd0);
    chk_out("R10 held source");
    cmp_det[1] = 1'b0;
    wr(3'd7, 16'hFFFF);
    chk_out("R10 write one");
    m_cmpf = '0; wr(3'd7, 16'd0); cyc(1);
    m_cmpen = '0; wr(3'd2, 16'd0); cyc(1);
    chk_out("R10 cleared");

    // R5: oscillator stop, first disabled then enabled
    osc_stop = 1'b1; @(negedge clk); osc_stop = 1'b0; m_ostf = 1'b1;
    @(negedge clk);
    chk_out("R5 disabled");
    m_osten = 1'b1; wr(3'd2, 16'h0008); cyc(1);
    chk_out("R5 enabled");
    m_ostf = 1'b0; wr(3'd7, 16'd0); cyc(1);
    chk_out("R5 cleared");
    m_osten = 1'b0; wr(3'd2, 16'd0);

    // R7 / R8: each pin in each mode, exact window and guarded clear
    set_psel(6'h3F, 6'h3F, 6'h3F);
    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 4; m++) begin
        int n;
        n = (m == 0) ? 1 : (m == 1) ? 8 : (m == 2) ? 16 : 128;
        m_mask = 9'(1 << (k * 3 + k));
        wr(3'd1, 16'(m_mask));
        wr(3'd3, 16'(m << (2 * k)));
        flt_n[k] = 1'b0;
        cyc(2 + n);
        chk("R7 before window", 32'(hiz_o), 32'd0);
        cyc(1);
        m_inf[k] = 1'b1;
        chk_out("R7 at window");
        if (m != 0) begin
          wr(3'd7, ~16'(1 << k));
          chk_out("R8 clear while low");
          flt_n[k] = 1'b1;
          cyc(3);
          wr(3'd7, ~16'(1 << k));
          m_inf[k] = 1'b0;
          cyc(1);
          chk_out("R8 clear after high");
        end else begin
          wr(3'd7, ~16'(1 << k));
          m_inf[k] = 1'b0;
          cyc(1);
          chk_out("R8 edge clear");
          flt_n[k] = 1'b1;
          cyc(3);
        end
      end
    end

    // R11: recovery needs every enabled pin flag cleared
    wr(3'd3, 16'd0);
    m_mask = 9'b000_000_011; wr(3'd1, 16'(m_mask));
    flt_n = 3'b000;
    cyc(4);
    m_inf = 3'b111;
    chk_out("R11 all set");
    wr(3'd7, ~16'h0001); m_inf[0] = 1'b0; cyc(1);
    chk_out("R11 one left");
    wr(3'd7, ~16'h0002); m_inf[1] = 1'b0; cyc(1);
    chk_out("R11 unmasked flag only");
    wr(3'd7, ~16'h0004); m_inf[2] = 1'b0; cyc(1);
    chk_out("R11 all clear");
    flt_n = 3'b111; cyc(3);

    // R9: pair conflict, guarded by timer stop
    m_mask = '0; wr(3'd1, 16'd0);
    m_ocden = 2'b11; wr(3'd2, 16'h0030);
    pwm_hi[1] = 1'b1; pwm_lo[1] = 1'b1;
    @(negedge clk); pwm_hi = '0; pwm_lo = '0; m_ocdf[0] = 1'b1;
    @(negedge clk);
    chk_out("R9 pair1 set");
    pwm_hi[PH+2] = 1'b1; pwm_lo[PH+2] = 1'b1;
    @(negedge clk); pwm_hi = '0; pwm_lo = '0; m_ocdf[1] = 1'b1;
    @(negedge clk);
    chk_out("R9 pair2 set");
    pwm_hi = 6'b000111; pwm_lo = 6'b111000;
    cyc(2);
    chk_out("R9 no conflict");
    pwm_hi = '0; pwm_lo = '0;
    wr(3'd7, 16'd0); cyc(1);
    chk_out("R9 clear ignored running");
    timer_stop = 1'b1;
    wr(3'd7, 16'd0); m_ocdf = '0; cyc(1);
    chk_out("R9 clear when stopped");
    timer_stop = 1'b0;

    // R12: flags_o matches the read port
    cmp_det = 3'b101; @(negedge clk); cmp_det = '0; m_cmpf = 3'b101;
    rd(3'd7, d);
    chk("R12 flags read", 32'(d), 32'(exp_flags()));
    chk("R12 flags out", 32'(flags_o), 32'(exp_flags()));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule